// File: doc/BRIEF.md
# Digital Delay-Locked Timing Channel

This block is one color channel of a closed timing loop that keeps the panel's control strobes aligned with the panel's own switching delay. A master reference strobe and five companion control strobes enter the channel and leave it through six matched shift-register delay lines. All six lines share one whole-cycle tap count, so the companions keep their phase relation to the master at the outputs. The delayed master travels through an external path (level shifter and panel) and returns as a feedback strobe.

A marker pulse from elsewhere in the system marks the cycle in which the feedback edge is expected. That marker is derived from the same master reference, which is shared by several channels. The channel compares the returning feedback edge with the marker and moves its tap count by one step to close the gap. When locked, the tap delay plus the external delay equals the chosen constant interval. An edge-select input picks which polarity of the feedback strobe is compared. The channel reports its current tap count and a lock flag.

Top module: `dll_timing_channel`

## Requirements
- R1: After reset the tap count is 14 (midpoint of 2..26), the lock flag is 0 and all six delayed outputs are 0.
- R2: Output bit 0 carries the master input, and output bits 5:1 carry companion inputs 4:0. An input value presented before clock edge k appears on its output after edge k+T-1, where T is the current tap count. All six lanes use the same T.
- R3: With edge-select 1, only rising edges of the feedback input are compared. With edge-select 0, only falling edges are compared. Edges of the other polarity are ignored.
- R4: A compared feedback edge 1 to 40 cycles after a marker pulse (late) lowers the tap count by one. The new value is visible after the clock edge that ends the cycle of the feedback edge.
- R5: A compared feedback edge followed by a marker 1 to 40 cycles later (early) raises the tap count by one. The new value is visible after the clock edge that ends the marker cycle.
- R6: A marker and a compared feedback edge in the same cycle leave the tap count unchanged. The fourth such match in a row sets the lock flag.
- R7: Any early or late result clears the lock flag and restarts the match run, even when the tap count is saturated.
- R8: The tap count never goes below 2 or above 26. A correction past either end leaves it at that end.
- R9: A marker not followed by a compared edge within 40 cycles, or a compared edge not followed by a marker within 40 cycles, is discarded. A discard changes neither the tap count nor the lock flag.
- R10: The tap count changes only at the end of a comparison and by at most one step. All six outputs switch to the new delay in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| edge_sel | input | 1 | 1: compare rising feedback edges, 0: compare falling feedback edges |
| ref_in | input | 1 | Master reference strobe |
| comp_in | input | 5 | Companion control strobes |
| fb_in | input | 1 | Feedback strobe returning from the panel |
| marker_in | input | 1 | One-cycle pulse marking the expected feedback cycle |
| dly_out | output | 6 | Delayed strobes: bit 0 master, bits 5:1 companions |
| tap_cnt | output | 5 | Current whole-cycle delay |
| locked | output | 1 | Set after four consecutive matches |

## Verification
The hardest states to reach are the two ends of the comparison window and the tap count held at a rail. The window ends are an edge exactly 40 cycles after a marker, a marker exactly 40 cycles after an edge, and an edge that never arrives. The stimulus drives marker and feedback at exact cycle offsets from a vector table and computes the expected tap and lock state after each comparison. It then runs long chains of one-sided corrections to pin the count at 2 and at 26. At each rail, and at the midpoint, a six-lane bit pattern is streamed through the delay lines and compared lane by lane with its own history.

// File: rtl/dll_pkg.sv
package dll_pkg;

  typedef enum logic [1:0] {
    PD_IDLE  = 2'd0,
    PD_LATE  = 2'd1,
    PD_EARLY = 2'd2
  } pd_state_t;

  // saturating one-step move of the tap count
  function automatic logic [4:0] tap_step(input logic [4:0] cur,
                                          input logic       up,
                                          input logic       dn,
                                          input logic [4:0] lo,
                                          input logic [4:0] hi);
    logic [4:0] res;
    res = cur;
    if (up && cur < hi)      res = cur + 5'd1;
    else if (dn && cur > lo) res = cur - 5'd1;
    return res;
  endfunction

  function automatic logic [4:0] tap_mid(input logic [4:0] lo,
                                         input logic [4:0] hi);
    logic [5:0] s;
    s = {1'b0, lo} + {1'b0, hi};
    return s[5:1];
  endfunction

endpackage

// File: rtl/dll_delay_line.sv
module dll_delay_line #(
  parameter int LANES   = 6,
  parameter int MAX_TAP = 26,
  parameter int MIN_TAP = 2,
  localparam int TAP_W  = $clog2(MAX_TAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_in,
  input  logic [TAP_W-1:0] tap,
  output logic [LANES-1:0] lane_out
);

  logic [TAP_W-1:0] sel;
  assign sel = tap - TAP_W'(1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [MAX_TAP-1:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[MAX_TAP-2:0], lane_in[g]};
    end
    assign lane_out[g] = sr[sel];
  end

  AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tap >= TAP_W'(MIN_TAP)) && (tap <= TAP_W'(MAX_TAP))); // R8

endmodule

// File: rtl/dll_phase_det.sv
module dll_phase_det
  import dll_pkg::*;
#(
  parameter int WINDOW = 40,
  localparam int CNT_W = $clog2(WINDOW)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_sel,
  input  logic fb_in,
  input  logic marker_in,
  output logic res_early,
  output logic res_late,
  output logic res_match,
  output logic res_drop
);

  pd_state_t        state, state_nxt;
  logic [CNT_W-1:0] win_cnt;
  logic             fb_q;
  logic             fb_edge;
  logic             win_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_q <= 1'b0;
    else        fb_q <= fb_in;
  end

  assign fb_edge = edge_sel ? (fb_in & ~fb_q) : (~fb_in & fb_q);
  assign win_end = (win_cnt == CNT_W'(WINDOW - 1));

  always_comb begin
    state_nxt = state;
    res_early = 1'b0;
    res_late  = 1'b0;
    res_match = 1'b0;
    res_drop  = 1'b0;
    case (state)
      PD_IDLE: begin
        if (marker_in && fb_edge) res_match = 1'b1;
        else if (marker_in)       state_nxt = PD_LATE;
        else if (fb_edge)         state_nxt = PD_EARLY;
      end
      PD_LATE: begin
        if (fb_edge) begin
          res_late  = 1'b1;
          state_nxt = PD_IDLE;
        end else if (win_end) begin
          res_drop  = 1'b1;
          state_nxt = PD_IDLE;
        end
      end
      PD_EARLY: begin
        if (marker_in) begin
          res_early = 1'b1;
          state_nxt = PD_IDLE;
        end else if (win_end) begin
          res_drop  = 1'b1;
          state_nxt = PD_IDLE;
        end
      end
      default: state_nxt = PD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PD_IDLE;
      win_cnt <= '0;
    end else begin
      state <= state_nxt;
      if (state == PD_IDLE || state_nxt == PD_IDLE) win_cnt <= '0;
      else                                           win_cnt <= win_cnt + CNT_W'(1);
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_early, res_late, res_match, res_drop})); // R6

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= CNT_W'(WINDOW - 1)); // R9

  AST_WAIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PD_IDLE && win_end) |=> (state == PD_IDLE)); // R9

endmodule

// File: rtl/dll_tap_ctrl.sv
module dll_tap_ctrl
  import dll_pkg::*;
#(
  parameter int MIN_TAP  = 2,
  parameter int MAX_TAP  = 26,
  parameter int LOCK_RUN = 4,
  localparam int TAP_W   = $clog2(MAX_TAP + 1),
  localparam int RUN_W   = $clog2(LOCK_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_early,
  input  logic             res_late,
  input  logic             res_match,
  input  logic             res_drop,
  output logic [TAP_W-1:0] tap,
  output logic             locked
);

  localparam logic [4:0] LO = 5'(MIN_TAP);
  localparam logic [4:0] HI = 5'(MAX_TAP);

  logic [RUN_W-1:0] run;
  logic             corr;

  assign corr = res_early | res_late;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap    <= TAP_W'(tap_mid(LO, HI));
      run    <= '0;
      locked <= 1'b0;
    end else if (corr) begin
      tap    <= TAP_W'(tap_step(5'(tap), res_early, res_late, LO, HI));
      run    <= '0;
      locked <= 1'b0;
    end else if (res_match) begin
      if (run < RUN_W'(LOCK_RUN)) run <= run + RUN_W'(1);
      if (run >= RUN_W'(LOCK_RUN - 1)) locked <= 1'b1;
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tap != $past(tap)) |-> ((tap == $past(tap) + TAP_W'(1)) ||
                             (tap + TAP_W'(1) == $past(tap)))); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_early || res_late) |=> $stable(tap)); // R10

  AST_DROP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    res_drop |=> ($stable(tap) && $stable(locked))); // R9

  AST_LOCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_early || res_late) |=> !locked); // R7

  AST_MATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    res_match |=> $stable(tap)); // R6

endmodule

// File: rtl/dll_timing_channel.sv
module dll_timing_channel #(
  parameter int COMP_N   = 5,
  parameter int MIN_TAP  = 2,
  parameter int MAX_TAP  = 26,
  parameter int WINDOW   = 40,
  parameter int LOCK_RUN = 4,
  localparam int LANES   = COMP_N + 1,
  localparam int TAP_W   = $clog2(MAX_TAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_sel,
  input  logic              ref_in,
  input  logic [COMP_N-1:0] comp_in,
  input  logic              fb_in,
  input  logic              marker_in,
  output logic [LANES-1:0]  dly_out,
  output logic [TAP_W-1:0]  tap_cnt,
  output logic              locked
);

  logic pd_early, pd_late, pd_match, pd_drop;

  dll_phase_det #(.WINDOW(WINDOW)) u_pd (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_sel  (edge_sel),
    .fb_in     (fb_in),
    .marker_in (marker_in),
    .res_early (pd_early),
    .res_late  (pd_late),
    .res_match (pd_match),
    .res_drop  (pd_drop)
  );

  dll_tap_ctrl #(
    .MIN_TAP  (MIN_TAP),
    .MAX_TAP  (MAX_TAP),
    .LOCK_RUN (LOCK_RUN)
  ) u_tap (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_early (pd_early),
    .res_late  (pd_late),
    .res_match (pd_match),
    .res_drop  (pd_drop),
    .tap       (tap_cnt),
    .locked    (locked)
  );

  dll_delay_line #(
    .LANES   (LANES),
    .MAX_TAP (MAX_TAP),
    .MIN_TAP (MIN_TAP)
  ) u_dl (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_in  ({comp_in, ref_in}),
    .tap      (tap_cnt),
    .lane_out (dly_out)
  );

  AST_RESET_MID: assert property (@(posedge clk)
    $rose(rst_n) |-> (tap_cnt == TAP_W'((MIN_TAP + MAX_TAP) / 2) && !locked)); // R1

endmodule

// File: tb/dll_timing_channel_tb_top.sv
module dll_timing_channel_tb_top;

  localparam int NOEDGE = 999;
  localparam int NV = 12;
  localparam int VEC_ES [NV]  = '{1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0};
  localparam int VEC_OFF [NV] = '{3, -5, 0, 0, 0, 0, NOEDGE, 40, -40, 1, -1, NOEDGE};

  logic       clk = 0;
  logic       rst_n = 0;
  logic       edge_sel = 1;
  logic       ref_in = 0;
  logic [4:0] comp_in = 0;
  logic       fb_in = 0;
  logic       marker_in = 0;
  logic [5:0] dly_out;
  logic [4:0] tap_cnt;
  logic       locked;

  int total = 0;
  int bad = 0;
  int m_tap = 14;
  int m_run = 0;
  bit m_lock = 0;

  always #2 clk = ~clk;

  dll_timing_channel dut_i (
    .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel), .ref_in(ref_in),
    .comp_in(comp_in), .fb_in(fb_in), .marker_in(marker_in),
    .dly_out(dly_out), .tap_cnt(tap_cnt), .locked(locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one comparison: edge offset relative to marker, NOEDGE for none
  task automatic run_cmp(input int es, input int off);
    int tm, te, span;
    @(negedge clk);
    edge_sel = es[0];
    fb_in = (es != 0) ? 1'b0 : 1'b1;
    marker_in = 0;
    repeat (2) @(negedge clk);
    if (off == NOEDGE) begin tm = 0; te = -1; span = 45; end
    else if (off >= 0) begin tm = 0; te = off; span = off; end
    else begin te = 0; tm = -off; span = -off; end
    for (int t = 0; t <= span; t++) begin
      marker_in = (t == tm);
      if (t == te) fb_in = (es != 0) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    marker_in = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic model(input int off);
    if (off == NOEDGE) return;
    if (off == 0) begin
      m_run++;
      if (m_run >= 4) m_lock = 1;
    end else begin
      m_run = 0;
      m_lock = 0;
      if (off > 0) m_tap = (m_tap > 2) ? m_tap - 1 : 2;
      else         m_tap = (m_tap < 26) ? m_tap + 1 : 26;
    end
  endtask

  task automatic cmp_and_check(input int es, input int off, input string req);
    run_cmp(es, off);
    model(off);
    chk(req, tap_cnt, m_tap);
    chk(req, locked, m_lock);
  endtask

  // stream a pattern through all six lanes and compare with its history
  task automatic lane_check(input string req);
    logic [5:0] hist [0:79];
    for (int n = 0; n < 80; n++) begin
      @(negedge clk);
      if (n >= m_tap) chk(req, dly_out, hist[n - m_tap]);
      hist[n] = 6'((n * 37) ^ (n >> 1) ^ (n * 5 >> 3));
      {comp_in, ref_in} = hist[n];
    end
    {comp_in, ref_in} = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 tap", tap_cnt, 14);
    chk("R1 lock", locked, 0);
    chk("R1 outputs", dly_out, 0);

    for (int v = 0; v < NV; v++) begin
      string req;
      if (VEC_OFF[v] == NOEDGE) req = "R9 discard";
      else if (VEC_OFF[v] == 0) req = "R6 match";
      else if (VEC_OFF[v] > 0)  req = "R4 late/R7";
      else                      req = "R5 early/R7";
      cmp_and_check(VEC_ES[v], VEC_OFF[v], req);
    end

    // R2 delay at the midpoint
    lane_check("R2 lanes at tap 14");

    // R3 wrong polarity ignored: falling edge while comparing rising
    @(negedge clk); edge_sel = 0; fb_in = 1;
    repeat (2) @(negedge clk);
    edge_sel = 1;
    @(negedge clk); marker_in = 1;
    @(negedge clk); marker_in = 0;
    @(negedge clk); fb_in = 0;
    repeat (46) @(negedge clk);
    chk("R3 ignored polarity", tap_cnt, m_tap);

    // R9 edge with no marker
    @(negedge clk); edge_sel = 1; fb_in = 0;
    repeat (2) @(negedge clk); fb_in = 1;
    repeat (46) @(negedge clk);
    chk("R9 edge without marker", tap_cnt, m_tap);

    // R6 lock again, then R7 clear with saturation
    for (int i = 0; i < 4; i++) cmp_and_check(i % 2, 0, "R6 lock run");
    chk("R6 locked", locked, 1);

    for (int i = 0; i < 13; i++) cmp_and_check(1, 1, "R8 down");
    chk("R8 floor", tap_cnt, 2);
    lane_check("R2 lanes at tap 2");
    for (int i = 0; i < 3; i++) cmp_and_check(0, 0, "R6 at floor");
    cmp_and_check(1, 2, "R7 clear at floor");
    chk("R7 floor unlocked", locked, 0);

    for (int i = 0; i < 25; i++) cmp_and_check(0, -2, "R8 up");
    chk("R8 ceiling", tap_cnt, 26);
    lane_check("R10 lanes at tap 26");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule